// File: doc/BRIEF.md
# Clock Output Enable Controller with Two-Wire Write Port

This block takes one buffered reference clock and fans it out to eighteen output pins, each of which can be turned on or off on its own. The enables live in a bank of eighteen bits. They are loaded over a write-only two-wire serial port: an open-drain data line and a clock line, both supplied by an external bus master. The block samples both lines with its own, faster system clock. It detects start and stop conditions, checks the first byte of each frame against its device byte and acknowledges what it accepts.

A frame opens with the device byte D3h. Two filler bytes follow, which are acknowledged and then dropped. Up to three payload bytes follow those. Each payload byte fills one lane of the enable bank, arriving most significant bit first.

A disabled output is held low. An enabled output follows the reference clock. A separate global enable input sets the tri-state control of every pin at once.

New enable values reach the pins only while the reference clock is low. Because of this, switching an output on or off never produces a shortened pulse.

Top module: `clkgate_i2c_ctrl`

## Requirements
- R1: After reset all eighteen enable bits are 1, so every output follows the reference clock before any frame is written.
- R2: The block acknowledges a first byte of exactly D3h by pulling the data line low during the ninth clock. Any other first byte gets no acknowledge. The block then drives nothing and changes nothing until the next start condition.
- R3: The second and third bytes of an accepted frame are acknowledged, and their values have no effect on the enables.
- R4: The first payload byte, received bit 7 first, sets the enables of outputs 7 down to 0, with bit n controlling output n.
- R5: The second payload byte sets the enables of outputs 15 down to 8, with bit n controlling output 8+n.
- R6: In the third payload byte, bit 7 sets the enable of output 17 and bit 6 sets the enable of output 16. Bits 5 to 0 are accepted and have no effect on any output.
- R7: An output whose enable is 0 stays low. An output whose enable is 1 equals the reference clock, so every output is low while the reference clock is low.
- R8: While the global enable input is 0, all eighteen tri-state controls are 0. While it is 1, all of them are 1.
- R9: Bytes that arrive after the third payload byte are acknowledged and leave the enables unchanged.
- R10: A stop or repeated start before the third payload byte keeps the payload lanes already received and leaves the remaining lanes unchanged.
- R11: An output changes its enable state only while the reference clock is low. A write completed while the reference clock is high does not reach the pins until the reference clock has gone low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Pulls the data line low when 1 (acknowledge) |
| ref_clk | input | 1 | Buffered reference clock to be distributed |
| out_en_all | input | 1 | Global pin enable; 0 puts every output in high impedance |
| clk_out | output | 18 | Gated copies of the reference clock |
| clk_out_oe | output | 18 | Per-pin tri-state control, 1 drives the pin |

## Verification
A wrong frame position or a wrong lane mapping would drive an acknowledge at the wrong place or leave the wrong pins toggling. This is visible at the pins during the first high phase of the reference clock after the frame ends. A decoder stuck in the ignore state, or one that never leaves it, shows up at once as a missing or extra acknowledge on the very next byte. A fault in the update gating would let the pins change during a paused high phase of the reference clock, and the paused-clock test observes the pins during that phase.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    typedef enum logic [1:0] {
        SL_IDLE = 2'd0,
        SL_RECV = 2'd1,
        SL_ACK  = 2'd2,
        SL_SKIP = 2'd3
    } slave_st_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/bus_sampler.sv
module bus_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_bit
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic                   scl_p;
        logic                   sda_p;
    } smp_t;

    smp_t smp_d, smp_q;
    logic scl_s, sda_s;

    assign scl_s = smp_q.scl_sh[SYNC_STAGES-1];
    assign sda_s = smp_q.sda_sh[SYNC_STAGES-1];

    always_comb begin
        smp_d        = smp_q;
        smp_d.scl_sh = {smp_q.scl_sh[SYNC_STAGES-2:0], scl_in};
        smp_d.sda_sh = {smp_q.sda_sh[SYNC_STAGES-2:0], sda_in};
        smp_d.scl_p  = scl_s;
        smp_d.sda_p  = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '1;
        end else begin
            smp_q <= smp_d;
        end
    end

    // Line events in the synchronized domain
    assign scl_rise  = scl_s && !smp_q.scl_p;
    assign scl_fall  = !scl_s && smp_q.scl_p;
    assign start_det = scl_s && smp_q.scl_p && smp_q.sda_p && !sda_s;
    assign stop_det  = scl_s && smp_q.scl_p && !smp_q.sda_p && sda_s;
    assign sda_bit   = sda_s;

endmodule

// File: rtl/i2c_wr_engine.sv
module i2c_wr_engine
    import clkgate_pkg::*;
#(
    parameter logic [7:0] ADDR_BYTE  = 8'hD3,
    parameter int         SKIP_BYTES = 2,
    parameter int         DATA_BYTES = 3,
    localparam int        LAST_IDX   = 1 + SKIP_BYTES + DATA_BYTES,
    localparam int        FIRST_DATA = 1 + SKIP_BYTES,
    localparam int        IDX_W      = $clog2(LAST_IDX + 1),
    localparam int        LANE_W     = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_bit,
    output logic              sda_drive,
    output logic              wr_stb,
    output logic [LANE_W-1:0] wr_lane,
    output logic [BYTE_W-1:0] wr_byte
);

    typedef struct packed {
        slave_st_e         st;
        logic [3:0]        bits;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] shift;
        logic              drive;
        logic              stb;
        logic [LANE_W-1:0] lane;
        logic [BYTE_W-1:0] wbyte;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d     = eng_q;
        eng_d.stb = 1'b0;
        if (start_det) begin
            eng_d.st    = SL_RECV;
            eng_d.bits  = 4'd0;
            eng_d.idx   = '0;
            eng_d.drive = 1'b0;
        end else if (stop_det) begin
            eng_d.st    = SL_IDLE;
            eng_d.drive = 1'b0;
        end else begin
            unique case (eng_q.st)
                SL_RECV: begin
                    if (scl_rise && eng_q.bits != 4'd8) begin
                        eng_d.shift = {eng_q.shift[BYTE_W-2:0], sda_bit};
                        eng_d.bits  = eng_q.bits + 4'd1;
                    end else if (scl_fall && eng_q.bits == 4'd8) begin
                        if (eng_q.idx == '0 && eng_q.shift != ADDR_BYTE) begin
                            eng_d.st = SL_SKIP;
                        end else begin
                            eng_d.st    = SL_ACK;
                            eng_d.drive = 1'b1;
                            if (eng_q.idx >= IDX_W'(FIRST_DATA) &&
                                eng_q.idx <  IDX_W'(LAST_IDX)) begin
                                eng_d.stb   = 1'b1;
                                eng_d.lane  = LANE_W'(eng_q.idx - IDX_W'(FIRST_DATA));
                                eng_d.wbyte = eng_q.shift;
                            end
                        end
                    end
                end
                SL_ACK: begin
                    if (scl_fall) begin
                        eng_d.drive = 1'b0;
                        eng_d.st    = SL_RECV;
                        eng_d.bits  = 4'd0;
                        if (eng_q.idx != IDX_W'(LAST_IDX)) begin
                            eng_d.idx = eng_q.idx + IDX_W'(1);
                        end
                    end
                end
                default: begin
                    eng_d.drive = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: SL_IDLE, bits: 4'd0, idx: '0, shift: '0,
                       drive: 1'b0, stb: 1'b0, lane: '0, wbyte: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign sda_drive = eng_q.drive;
    assign wr_stb    = eng_q.stb;
    assign wr_lane   = eng_q.lane;
    assign wr_byte   = eng_q.wbyte;

endmodule

// File: rtl/enable_bank.sv
module enable_bank
    import clkgate_pkg::*;
#(
    parameter int NUM_OUT = 18,
    parameter int LANE_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_clk,
    input  logic               wr_stb,
    input  logic [LANE_W-1:0]  wr_lane,
    input  logic [BYTE_W-1:0]  wr_byte,
    output logic [NUM_OUT-1:0] en_live
);

    // A partial last lane is packed against the top bits of its byte
    function automatic int bit_of(input int idx);
        int lane_cnt;
        lane_cnt = NUM_OUT - (idx / BYTE_W) * BYTE_W;
        if (lane_cnt > BYTE_W) lane_cnt = BYTE_W;
        return (idx % BYTE_W) + (BYTE_W - lane_cnt);
    endfunction

    typedef struct packed {
        logic [NUM_OUT-1:0] en;
        logic [NUM_OUT-1:0] live;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_OUT; i++) begin
            if (wr_stb && int'(wr_lane) == i / BYTE_W) begin
                bank_d.en[i] = wr_byte[3'(bit_of(i))];
            end
        end
        if (!ref_clk) begin
            bank_d.live = bank_q.en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '1;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign en_live = bank_q.live;

endmodule

// File: rtl/clkgate_i2c_ctrl.sv
module clkgate_i2c_ctrl
    import clkgate_pkg::*;
#(
    parameter int         NUM_OUT     = 18,
    parameter logic [7:0] ADDR_BYTE   = 8'hD3,
    parameter int         SKIP_BYTES  = 2,
    parameter int         DATA_BYTES  = 3,
    parameter int         SYNC_STAGES = 2,
    localparam int        LANE_W      = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_oe,
    input  logic               ref_clk,
    input  logic               out_en_all,
    output logic [NUM_OUT-1:0] clk_out,
    output logic [NUM_OUT-1:0] clk_out_oe
);

    logic              scl_rise, scl_fall, start_det, stop_det, sda_bit;
    logic              wr_stb;
    logic [LANE_W-1:0] wr_lane;
    logic [BYTE_W-1:0] wr_byte;
    logic [NUM_OUT-1:0] en_live;

    bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_bit   (sda_bit)
    );

    i2c_wr_engine #(
        .ADDR_BYTE  (ADDR_BYTE),
        .SKIP_BYTES (SKIP_BYTES),
        .DATA_BYTES (DATA_BYTES)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_bit   (sda_bit),
        .sda_drive (sda_oe),
        .wr_stb    (wr_stb),
        .wr_lane   (wr_lane),
        .wr_byte   (wr_byte)
    );

    enable_bank #(.NUM_OUT(NUM_OUT), .LANE_W(LANE_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_clk (ref_clk),
        .wr_stb  (wr_stb),
        .wr_lane (wr_lane),
        .wr_byte (wr_byte),
        .en_live (en_live)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_pin
        assign clk_out[g]    = ref_clk & en_live[g];
        assign clk_out_oe[g] = out_en_all;
    end

endmodule

// File: rtl/clkgate_i2c_ctrl_checker.sv
module clkgate_i2c_ctrl_checker #(
    parameter int NUM_OUT = 18
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_in,
    input logic               sda_oe,
    input logic               ref_clk,
    input logic               out_en_all,
    input logic [NUM_OUT-1:0] clk_out,
    input logic [NUM_OUT-1:0] clk_out_oe,
    input logic [NUM_OUT-1:0] en_live
);

    assert_reset_enabled_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (&en_live));

    assert_ack_starts_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_in);

    assert_ack_ends_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_in);

    assert_low_phase_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_clk |-> (clk_out == '0));

    assert_tristate_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_all |-> (clk_out_oe == '0));

    assert_tristate_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_all |-> (&clk_out_oe));

    assert_apply_in_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_live) |-> !$past(ref_clk));

endmodule

bind clkgate_i2c_ctrl clkgate_i2c_ctrl_checker #(.NUM_OUT(NUM_OUT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl_in),
    .sda_oe     (sda_oe),
    .ref_clk    (ref_clk),
    .out_en_all (out_en_all),
    .clk_out    (clk_out),
    .clk_out_oe (clk_out_oe),
    .en_live    (en_live)
);

// File: tb/clkgate_i2c_ctrl_test.sv
`timescale 1ns/1ps
module clkgate_i2c_ctrl_test;

    localparam int N = 18;
    localparam int Q = 200;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scl = 1'b1;
    logic         m_sda = 1'b1;
    logic         sda_oe;
    logic         sda_line;
    logic         ref_clk = 1'b0;
    logic         ref_run = 1'b1;
    logic         out_en_all = 1'b1;
    logic [N-1:0] clk_out, clk_out_oe;
    logic [N-1:0] mask;
    int           tests = 0;
    int           fails = 0;

    assign sda_line = m_sda && !sda_oe;

    clkgate_i2c_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl),
        .sda_in     (sda_line),
        .sda_oe     (sda_oe),
        .ref_clk    (ref_clk),
        .out_en_all (out_en_all),
        .clk_out    (clk_out),
        .clk_out_oe (clk_out_oe)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            #200;
            if (ref_run) ref_clk = ~ref_clk;
        end
    end

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] apply_lane(input logic [N-1:0] m, input int lane,
                                                input logic [7:0] b);
        logic [N-1:0] r;
        r = m;
        if (lane == 0) r[7:0] = b;
        else if (lane == 1) r[15:8] = b;
        else if (lane == 2) r[17:16] = b[7:6];
        return r;
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; #Q; scl = 1'b1; #Q; m_sda = 1'b0; #Q; scl = 1'b0; #Q;
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; #Q; scl = 1'b1; #Q; m_sda = 1'b1; #Q;
    endtask

    task automatic bus_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
        end
        m_sda = 1'b1; #Q; scl = 1'b1; #Q;
        ack = !sda_line;
        #Q; scl = 1'b0; #Q;
    endtask

    task automatic send_chk(input string tag, input logic [7:0] b, input logic exp_ack);
        logic a;
        bus_byte(b, a);
        chk(tag, N'(a), N'(exp_ack));
    endtask

    task automatic write_frame(input logic [7:0] cmd, input logic [7:0] cnt,
                               input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
        bus_start();
        send_chk("R2 address ack", 8'hD3, 1'b1);
        send_chk("R3 command ack", cmd, 1'b1);
        send_chk("R3 count ack", cnt, 1'b1);
        send_chk("R4 byte0 ack", d0, 1'b1);
        send_chk("R5 byte1 ack", d1, 1'b1);
        send_chk("R6 byte2 ack", d2, 1'b1);
        mask = apply_lane(mask, 0, d0);
        mask = apply_lane(mask, 1, d1);
        mask = apply_lane(mask, 2, d2);
    endtask

    task automatic check_pins(input string tag);
        @(negedge ref_clk); #60;
        chk({tag, " low phase R7"}, clk_out, '0);
        @(posedge ref_clk); #60;
        chk({tag, " high phase"}, clk_out, mask);
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        mask = '1;
        #100; rst_n = 1'b1; #200;

        // R1 reset state, R8 pins driven
        check_pins("R1 reset enables");
        chk("R8 oe high", clk_out_oe, '1);
        chk("R2 idle no drive", N'(sda_oe), '0);

        // R3 R4 R5 R6: filler values arbitrary, reserved bits set
        write_frame(8'hA5, 8'h3C, 8'h5A, 8'hC3, 8'hBF);
        bus_stop();
        check_pins("R4 R5 R6 frame A");

        // R3 R6: other filler, reserved bits clear
        write_frame(8'h00, 8'hFF, 8'hFF, 8'h00, 8'h40);
        bus_stop();
        check_pins("R3 R6 frame B");

        // R2: first byte D2h is not accepted; nothing after it is acked
        bus_start();
        send_chk("R2 D2 no ack", 8'hD2, 1'b0);
        send_chk("R2 ignored cmd", 8'h11, 1'b0);
        send_chk("R2 ignored cnt", 8'h22, 1'b0);
        send_chk("R2 ignored d0", 8'h00, 1'b0);
        send_chk("R2 ignored d1", 8'h00, 1'b0);
        send_chk("R2 ignored d2", 8'h00, 1'b0);
        bus_stop();
        check_pins("R2 mask unchanged");

        bus_start();
        send_chk("R2 other addr no ack", 8'h52, 1'b0);
        send_chk("R2 other addr data", 8'h00, 1'b0);
        bus_stop();
        check_pins("R2 mask unchanged 2");

        // R9: extra bytes acked and ignored
        write_frame(8'h01, 8'h03, 8'h0F, 8'hF0, 8'hC0);
        send_chk("R9 extra ack 1", 8'h00, 1'b1);
        send_chk("R9 extra ack 2", 8'h00, 1'b1);
        bus_stop();
        check_pins("R9 extra bytes");

        // R10: stop after one payload byte
        bus_start();
        send_chk("R10 addr", 8'hD3, 1'b1);
        send_chk("R10 cmd", 8'h77, 1'b1);
        send_chk("R10 cnt", 8'h03, 1'b1);
        send_chk("R10 d0", 8'h33, 1'b1);
        mask = apply_lane(mask, 0, 8'h33);
        bus_stop();
        check_pins("R10 partial stop");

        // R10: repeated start after two payload bytes
        bus_start();
        send_chk("R10 rs addr", 8'hD3, 1'b1);
        send_chk("R10 rs cmd", 8'h00, 1'b1);
        send_chk("R10 rs cnt", 8'h00, 1'b1);
        send_chk("R10 rs d0", 8'h11, 1'b1);
        send_chk("R10 rs d1", 8'h22, 1'b1);
        mask = apply_lane(mask, 0, 8'h11);
        mask = apply_lane(mask, 1, 8'h22);
        bus_start();
        send_chk("R10 rs new addr", 8'h00, 1'b0);
        bus_stop();
        check_pins("R10 repeated start");

        // R8: global enable off and back on
        out_en_all = 1'b0; #100;
        chk("R8 oe low", clk_out_oe, '0);
        out_en_all = 1'b1; #100;
        chk("R8 oe restored", clk_out_oe, '1);

        // R11: write during a paused high phase
        @(posedge ref_clk); #20;
        ref_run = 1'b0;
        write_frame(8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        bus_stop();
        #400;
        chk("R11 held while high", clk_out, apply_lane(apply_lane(18'h0, 0, 8'h11),
                                                       1, 8'h22) | 18'h30000);
        ref_run = 1'b1;
        check_pins("R11 applied after low");
        #300;
        chk("R7 disabled stays low", clk_out, '0);

        // R7: every pin enabled again
        write_frame(8'h00, 8'h00, 8'hFF, 8'hFF, 8'hFF);
        bus_stop();
        check_pins("R7 all on");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule